// File: doc/BRIEF.md
# Mode-Configurable Register Bank

This block is a bank of 32-bit control and status words behind a small memory-mapped bus. The bus addresses bytes, and word n sits at byte address 4·n. Each word is given one of five access modes by a parameter. The mode decides three things: whether a write is kept or only flashed to the fabric for one cycle, whether a read returns the stored word or the value the fabric drives right now, and whether a direction is open to the bus at all.

Writes and reads have separate valid/ready channels. Both ready signals are always high, so a request is taken on any clock edge where its valid is high. The read answer comes back with a data-valid strobe one cycle after the request is taken.

The number of words, the mode of each word and the reset value of each held word are parameters. Each reset value is a whole word that already contains every field's default at that field's bit offset.

Top module: `mode_regbank`

## Requirements
- R1: Word n answers at byte address 4·n. Its mode is the 3-bit code at bits [3n+2:3n] of MODES, with these meanings: 0 = read-only, 1 = write-only, 2 = read-write, 3 = write-pulse, 4 = read plus write-pulse. Word n uses bits [32n+31:32n] of fab_in and fab_out.
- R2: A read-only word returns its fab_in slice as sampled on the acceptance edge. Bus writes to it are ignored, and its fab_out slice stays zero.
- R3: A write-only word drives the written value on fab_out from the cycle after acceptance until the next write. A read of it returns zero.
- R4: A read-write word drives the written value on fab_out, and a read returns that held value.
- R5: A write-pulse word drives the written value on fab_out for exactly the one cycle after acceptance, then zero. A read of it returns zero.
- R6: A read plus write-pulse word returns its fab_in slice on a read, and a write to it gives a one-cycle pulse on fab_out.
- R7: While rst_n is low at a clock edge, each held word loads its RESET_VALS slice, every pulse output clears to zero, and rd_dvalid goes low.
- R8: An access that is not word-aligned, or whose address is past the last word, changes no fab_out value. A read of such an address returns zero with rd_dvalid high.
- R9: wr_ready and rd_ready are high. rd_dvalid is high in exactly the cycle after an accepted read, and rd_data is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write accepted when high together with wr_valid |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 32 | Write data |
| rd_valid | input | 1 | Read request |
| rd_ready | output | 1 | Read accepted when high together with rd_valid |
| rd_addr | input | ADDR_W | Read byte address |
| rd_dvalid | output | 1 | Read data valid, one cycle after acceptance |
| rd_data | output | 32 | Read data |
| fab_in | input | 32·NUM_REGS | Values supplied by the fabric, one word per register |
| fab_out | output | 32·NUM_REGS | Held or pulsed values driven to the fabric |

## Verification
The default bank contains one word of each mode. Each word is written and read with distinct data patterns, so the bench can tell a stored value apart from a live fabric value and from zero. Before each read, the fab_in words are set to values that no write uses. This exposes a mode that returns the wrong source.

Pulse words are sampled in the cycle after the write and again in the cycle after that. This separates a true one-cycle pulse from a held value. Misaligned addresses, addresses past the last word, and writes to the read-only word are followed by a sweep of every fab_out word. This catches a decoder that aliases addresses. A reset in the middle of the run checks that held words return to their defaults rather than keeping the last write.

// File: rtl/mode_regbank_pkg.sv
// Package: shared mode codes and word width for the register bank.
package mode_regbank_pkg;
    localparam int WORD_W = 32;

    // Access mode of one word; the encoding is part of the MODES parameter layout.
    typedef enum logic [2:0] {
        MODE_RO      = 3'd0,
        MODE_WO      = 3'd1,
        MODE_RW      = 3'd2,
        MODE_WPULSE  = 3'd3,
        MODE_RWPULSE = 3'd4
    } acc_mode_e;
endpackage

// File: rtl/mode_regbank_decode.sv
// Module: address decoder.
// Turns a byte address into a one-hot word select plus a hit flag.
// Assumes words are 4 bytes wide and word n sits at byte address 4*n.
// A misaligned address, or one past the last word, gives hit = 0 and no select.
module mode_regbank_decode #(
    parameter int NUM_REGS = 5,
    parameter int ADDR_W   = 8
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic                hit,
    output logic [NUM_REGS-1:0] sel
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    assign idx = addr[ADDR_W-1:2];

    // Hit when the address is word-aligned and inside the bank.
    assign hit = (addr[1:0] == 2'b00) && (idx < IDX_W'(NUM_REGS));

    // One select line per word, qualified by the hit flag.
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
        assign sel[i] = hit && (idx == IDX_W'(i));
    end
endmodule

// File: rtl/mode_regbank_cell.sv
// Module: one register word.
// The MODE parameter picks the storage variant:
//   - held word (write-only, read-write) or pulse word (write-pulse, read plus write-pulse), or
//   - no storage at all (read-only).
// rd_val is what a bus read of this word returns.
// Assumes wr_en is already qualified by the address decode and the handshake.
module mode_regbank_cell
    import mode_regbank_pkg::*;
#(
    parameter acc_mode_e         MODE      = MODE_RW,
    parameter logic [WORD_W-1:0] RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [WORD_W-1:0] fab_in,
    output logic [WORD_W-1:0] fab_out,
    output logic [WORD_W-1:0] rd_val
);
    if (MODE == MODE_WO || MODE == MODE_RW) begin : g_held
        logic [WORD_W-1:0] held_q;

        // Keep the last written word; reload the default on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)     held_q <= RESET_VAL;
            else if (wr_en) held_q <= wr_data;
        end

        assign fab_out = held_q;
        assign rd_val  = (MODE == MODE_RW) ? held_q : '0;

        logic unused_fab;
        assign unused_fab = ^fab_in;

        // A write shows up on the fabric output in the next cycle.
        assert_held_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |=> fab_out == $past(wr_data));
        // Without a write, the held word does not move.
        assert_held_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en |=> $stable(fab_out));
    end else if (MODE == MODE_WPULSE || MODE == MODE_RWPULSE) begin : g_pulse
        logic [WORD_W-1:0] pulse_q;

        // Capture the written word for one cycle, zero otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n)     pulse_q <= '0;
            else if (wr_en) pulse_q <= wr_data;
            else            pulse_q <= '0;
        end

        assign fab_out = pulse_q;
        assign rd_val  = (MODE == MODE_RWPULSE) ? fab_in : '0;

        logic unused_rst;
        assign unused_rst = 1'b0;

        // A pulse carries the written word in the cycle after the write.
        assert_pulse_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |=> fab_out == $past(wr_data));
        // Without a write, the pulse output is zero in the next cycle.
        assert_pulse_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en |=> fab_out == '0);
    end else begin : g_ro
        // Read-only: bus writes have no target, so the output stays zero.
        assign fab_out = '0;
        assign rd_val  = fab_in;

        logic unused_ro;
        assign unused_ro = ^{clk, rst_n, wr_en, wr_data};
    end
endmodule

// File: rtl/mode_regbank_rdmux.sv
// Module: read multiplexer.
// Selects one word's read value with a one-hot select.
// The output is zero when no word is selected, which covers misses.
module mode_regbank_rdmux #(
    parameter int NUM_REGS = 5,
    parameter int WORD_W   = 32
) (
    input  logic [NUM_REGS*WORD_W-1:0] rd_vals,
    input  logic [NUM_REGS-1:0]        sel,
    output logic [WORD_W-1:0]          rd_word
);
    // AND-OR mux over all words.
    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            rd_word |= rd_vals[i*WORD_W +: WORD_W] & {WORD_W{sel[i]}};
        end
    end
endmodule

// File: rtl/mode_regbank.sv
// Module: mode-configurable register bank (top).
// Each word has an access mode taken from the MODES parameter (3 bits per word).
// Held words start from RESET_VALS, given as whole words with every field
// default already in place. Both bus channels are always ready. Read data is
// registered and returned with rd_dvalid one cycle after acceptance.
// Reset is synchronous and active low.
module mode_regbank
    import mode_regbank_pkg::*;
#(
    parameter int                        NUM_REGS   = 5,
    parameter int                        ADDR_W     = 8,
    parameter logic [NUM_REGS*3-1:0]     MODES      = {3'd4, 3'd3, 3'd2, 3'd1, 3'd0},
    parameter logic [NUM_REGS*32-1:0]    RESET_VALS = {32'h0, 32'h0, 32'h1234_0001,
                                                       32'h0000_00A5, 32'h0}
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_valid,
    output logic                       wr_ready,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [31:0]                wr_data,
    input  logic                       rd_valid,
    output logic                       rd_ready,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic                       rd_dvalid,
    output logic [31:0]                rd_data,
    input  logic [NUM_REGS*32-1:0]     fab_in,
    output logic [NUM_REGS*32-1:0]     fab_out
);
    localparam int BUS_W = NUM_REGS * WORD_W;

    logic                wr_hit, rd_hit, wr_fire, rd_fire;
    logic [NUM_REGS-1:0] wr_sel, rd_sel;
    logic [BUS_W-1:0]    rd_vals;
    logic [WORD_W-1:0]   rd_word;

    assign wr_ready = 1'b1;
    assign rd_ready = 1'b1;
    assign wr_fire  = wr_valid && wr_ready;
    assign rd_fire  = rd_valid && rd_ready;

    mode_regbank_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_wr_dec (
        .addr(wr_addr), .hit(wr_hit), .sel(wr_sel)
    );

    mode_regbank_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_rd_dec (
        .addr(rd_addr), .hit(rd_hit), .sel(rd_sel)
    );

    // One cell per word; the mode and reset value come from the packed parameters.
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
        mode_regbank_cell #(
            .MODE     (acc_mode_e'(MODES[i*3 +: 3])),
            .RESET_VAL(RESET_VALS[i*WORD_W +: WORD_W])
        ) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_fire && wr_sel[i]),
            .wr_data(wr_data),
            .fab_in (fab_in[i*WORD_W +: WORD_W]),
            .fab_out(fab_out[i*WORD_W +: WORD_W]),
            .rd_val (rd_vals[i*WORD_W +: WORD_W])
        );
    end

    mode_regbank_rdmux #(.NUM_REGS(NUM_REGS), .WORD_W(WORD_W)) u_rdmux (
        .rd_vals(rd_vals), .sel(rd_sel), .rd_word(rd_word)
    );

    // Register the read answer and its valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_dvalid <= 1'b0;
            rd_data   <= '0;
        end else begin
            rd_dvalid <= rd_fire;
            if (rd_fire) rd_data <= rd_word;
        end
    end

    // An accepted read yields a data strobe in the next cycle.
    assert_rd_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fire |=> rd_dvalid);
    // No strobe appears without a read.
    assert_rd_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_fire |=> !rd_dvalid);
    // A read that misses the bank returns zero.
    assert_rd_miss_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && !rd_hit) |=> rd_data == '0);
    // At most one word is selected by either decoder.
    assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel) && $onehot0(rd_sel));
endmodule

// File: tb/tb_mode_regbank.sv
module tb_mode_regbank;
    localparam int NUM_REGS = 5;
    localparam int ADDR_W   = 8;
    localparam logic [31:0] FAB0 = 32'hCAFE_0000;
    localparam logic [31:0] FAB4 = 32'h0000_BEEF;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   wr_valid = 1'b0, rd_valid = 1'b0;
    logic                   wr_ready, rd_ready, rd_dvalid;
    logic [ADDR_W-1:0]      wr_addr = '0, rd_addr = '0;
    logic [31:0]            wr_data = '0, rd_data;
    logic [NUM_REGS*32-1:0] fab_in = '0;
    logic [NUM_REGS*32-1:0] fab_out;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #4ns clk = ~clk;

    mode_regbank #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .rd_dvalid(rd_dvalid), .rd_data(rd_data),
        .fab_in(fab_in), .fab_out(fab_out)
    );

    // Watchdog: a hung run is counted as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] fo(input int n);
        return fab_out[n*32 +: 32];
    endfunction

    // Write: raise valid at a negedge; accepted at the next posedge; held values
    // and pulses are visible at the following negedge.
    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    // Read: accepted at the posedge; data and strobe are visible at the next negedge.
    task automatic do_read(input logic [ADDR_W-1:0] a, output logic [31:0] d,
                           output logic dv);
        @(negedge clk);
        rd_valid = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_valid = 1'b0;
        d = rd_data; dv = rd_dvalid;
    endtask

    // Vector table: {is_read, addr, data, expected read data, requirement number}.
    localparam int NVEC = 12;
    localparam logic [76:0] VEC [NVEC] = '{
        {1'b0, 8'h04, 32'h1111_2222, 32'h0,          4'd3},
        {1'b1, 8'h04, 32'h0,         32'h0,          4'd3},
        {1'b0, 8'h08, 32'hDEAD_BEEF, 32'h0,          4'd4},
        {1'b1, 8'h08, 32'h0,         32'hDEAD_BEEF,  4'd4},
        {1'b1, 8'h00, 32'h0,         FAB0,           4'd2},
        {1'b1, 8'h10, 32'h0,         FAB4,           4'd6},
        {1'b1, 8'h0C, 32'h0,         32'h0,          4'd5},
        {1'b1, 8'h14, 32'h0,         32'h0,          4'd8},
        {1'b1, 8'h09, 32'h0,         32'h0,          4'd8},
        {1'b0, 8'h08, 32'h0000_5555, 32'h0,          4'd4},
        {1'b1, 8'h08, 32'h0,         32'h0000_5555,  4'd4},
        {1'b1, 8'hFC, 32'h0,         32'h0,          4'd8}
    };

    initial begin
        logic [31:0] d;
        logic        dv;
        fab_in[0*32 +: 32] = FAB0;
        fab_in[4*32 +: 32] = FAB4;
        repeat (3) @(negedge clk);

        // R7: reset state, sampled while reset is still held.
        check("R7 word1 default", fo(1), 32'h0000_00A5);
        check("R7 word2 default", fo(2), 32'h1234_0001);
        check("R7 pulse word3 clear", fo(3), 32'h0);
        check("R7 pulse word4 clear", fo(4), 32'h0);
        check("R7 rd_dvalid low", {31'b0, rd_dvalid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 ready high", {30'b0, wr_ready, rd_ready}, 32'h3);

        // Table walk: each read entry compares read data; each write entry has no check.
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][76]) begin
                do_read(VEC[i][75:68], d, dv);
                check($sformatf("R%0d vector %0d", VEC[i][3:0], i), d, VEC[i][35:4]);
                check("R9 strobe after read", {31'b0, dv}, 32'h1);
            end else begin
                do_write(VEC[i][75:68], VEC[i][67:36]);
            end
        end

        // R3: the written value is held on the write-only word.
        check("R3 word1 held", fo(1), 32'h1111_2222);
        // R4: the read-write word drives its held value.
        check("R4 word2 held", fo(2), 32'h0000_5555);

        // R9: no strobe in a cycle without a read.
        @(negedge clk);
        check("R9 no strobe idle", {31'b0, rd_dvalid}, 32'h0);

        // R5: write-pulse is high for one cycle, then zero.
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = 8'h0C; wr_data = 32'h0000_0077;
        @(negedge clk);
        wr_valid = 1'b0;
        check("R5 pulse present", fo(3), 32'h0000_0077);
        @(negedge clk);
        check("R5 pulse gone", fo(3), 32'h0);

        // R6: read plus write-pulse word pulses on write.
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = 8'h10; wr_data = 32'hA5A5_0F0F;
        @(negedge clk);
        wr_valid = 1'b0;
        check("R6 pulse present", fo(4), 32'hA5A5_0F0F);
        @(negedge clk);
        check("R6 pulse gone", fo(4), 32'h0);
        fab_in[4*32 +: 32] = 32'h1357_9BDF;
        do_read(8'h10, d, dv);
        check("R6 live fabric read", d, 32'h1357_9BDF);

        // R2: a write to the read-only word is ignored.
        do_write(8'h00, 32'hFFFF_FFFF);
        check("R2 fab_out stays zero", fo(0), 32'h0);
        do_read(8'h00, d, dv);
        check("R2 read still fabric", d, FAB0);

        // R8: misaligned and out-of-range writes change nothing.
        do_write(8'h0A, 32'hFFFF_0000);
        do_write(8'h14, 32'h0BAD_0BAD);
        do_write(8'h05, 32'h0BAD_0BAD);
        for (int n = 0; n < NUM_REGS; n++) begin
            logic [31:0] e;
            e = (n == 1) ? 32'h1111_2222 : (n == 2) ? 32'h0000_5555 : 32'h0;
            check($sformatf("R8 word%0d unchanged", n), fo(n), e);
        end

        // R1: word 2 answers at byte address 8 only; address 8 does not reach word 1.
        do_write(8'h08, 32'h0000_0808);
        check("R1 word2 address", fo(2), 32'h0000_0808);
        check("R1 word1 untouched", fo(1), 32'h1111_2222);

        // R7: a reset in the middle of the run restores the held defaults.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R7 word2 back to default", fo(2), 32'h1234_0001);
        check("R7 word1 back to default", fo(1), 32'h0000_00A5);
        rst_n = 1'b1;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule